// File: doc/BRIEF.md
# Calendar alarm matcher

This block holds a five-field alarm time (month, day, hour, minute, second) in BCD. It compares that alarm against a running BCD calendar that arrives on input ports. The comparison is made once per one-second tick. When every field agrees on that tick, a sticky alarm flag is set. While the flag is set and the alarm enable bit is on, an active-low level interrupt is driven.

Software reaches the block through a byte-wide register port: address, write data, write strobe and a combinational read-data bus. The alarm-month register has two extra bits in its upper part:

- an interrupt enable bit;
- an unrelated square-wave enable bit, which is brought out on its own pin.

A separate flags register holds three sticky bits: the alarm flag, an oscillator-fail flag and a battery-low flag. Software clears any of them by writing a 0 to that bit. Writing a 1 to a bit leaves it as it is.

Top module: `rtc_alarm_match`

## Requirements
- R1: The alarm registers are at addresses 0x0A (month), 0x0B (day), 0x0C (hour), 0x0D (minute) and 0x0E (second). Each holds a full byte written through the port and reads back unchanged.
- R2: In the month register at 0x0A, bit 7 is the alarm interrupt enable and bit 6 is the square-wave enable. The `sqw_en` output equals bit 6. Bit 6 changes only on a write to 0x0A.
- R3: The alarm flag is bit 6 of the flags register at 0x0F. Once set, it stays set until a write to 0x0F carries 0 in bit 6. Writing 1 there has no effect.
- R4: `irq_n` is a level that is low exactly while the alarm flag and the enable bit are both 1. It follows a change of either one at the same clock edge that changes the register.
- R5: Only some bits take part in the compare. For month, day and hour these are bits 5:0; for minute and second they are bits 6:0. The remaining bits of either operand never affect a match.
- R6: The alarm flag is set only at a clock edge where `tick` is high and all five masked fields are equal. When `tick` is low, the flag does not set, even if the fields are equal.
- R7: In the flags register, bit 2 is the oscillator-fail flag and bit 4 is the battery-low flag. Each is set by a one-cycle pulse on its input. Each is cleared only by writing 0 to its own bit, and a write does not change the bits it does not clear. Bits 7, 5, 3, 1 and 0 read as 0.
- R8: Reads of any address outside 0x0A..0x0F return 0. Writes to those addresses change no register.
- R9: Synchronous reset clears all alarm bytes, including the enable and square-wave bits, and all flags. It leaves `irq_n` high.
- R10: Suppose a flags write clears the alarm flag in the same cycle as a matching tick. Then the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| tick | input | 1 | One-second compare strobe |
| now_mon | input | 8 | Current month, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_sec | input | 8 | Current second, BCD |
| osc_fail_set | input | 1 | Pulse that sets the oscillator-fail flag |
| batt_low_set | input | 1 | Pulse that sets the battery-low flag |
| irq_n | output | 1 | Alarm interrupt, active low level |
| sqw_en | output | 1 | Square-wave enable bit |

## Verification
A corrupted alarm byte shows up on the read port on the next read of its address. It also shows up as a missing or extra flag after the next tick that matches or nearly matches. A wrong compare mask is exposed by times whose bits differ only above or only inside the masked range. A flag that clears or sets at the wrong time appears in the flags readback and on `irq_n` one clock edge after the offending tick or write. A slip in the ordering of set and clear is caught by a tick that coincides with a clearing write.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int REG_W      = 8;
    localparam int NUM_FIELDS = 5;   // month, day, hour, minute, second
    localparam int ADDR_W     = 5;

    localparam logic [ADDR_W-1:0] ALM_BASE  = 5'h0A;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = 5'h0F;

    // bit positions inside the month register and the flags register
    localparam int EN_BIT  = 7;
    localparam int SQW_BIT = 6;
    localparam int AF_BIT  = 6;
    localparam int BL_BIT  = 4;
    localparam int OF_BIT  = 2;

    // field slot order inside the packed alarm/time vectors
    localparam int FLD_MON = 0;

    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        logic alarm;
        logic batt;
        logic osc;
    } flags_t;

    // the upper three fields compare six bits, the lower two compare seven
    function automatic reg_t field_mask(input int idx);
        return (idx < 3) ? reg_t'(8'h3F) : reg_t'(8'h7F);
    endfunction

    function automatic reg_t flags_to_byte(input flags_t f);
        reg_t b;
        b         = '0;
        b[AF_BIT] = f.alarm;
        b[BL_BIT] = f.batt;
        b[OF_BIT] = f.osc;
        return b;
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int                NF   = NUM_FIELDS,
    parameter logic [ADDR_W-1:0] BASE = ALM_BASE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  reg_t                wr_data,
    output reg_t [NF-1:0]       alm_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NF; i++) begin
                if (addr == BASE + ADDR_W'(i)) begin
                    alm_q[i] <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS
) (
    input  reg_t [NF-1:0] alm,
    input  reg_t [NF-1:0] now,
    output logic          hit
);

    logic [NF-1:0] eq;

    for (genvar i = 0; i < NF; i++) begin : g_field
        localparam reg_t MASK = field_mask(i);
        assign eq[i] = ((alm[i] ^ now[i]) & MASK) == '0;
    end

    assign hit = &eq;

endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
    import rtc_alarm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   alarm_set,
    input  logic   osc_set,
    input  logic   batt_set,
    input  logic   alarm_clr,
    input  logic   osc_clr,
    input  logic   batt_clr,
    output flags_t flags_q
);

    // a set event in the same cycle as a clearing write wins
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.alarm <= alarm_set | (flags_q.alarm & ~alarm_clr);
            flags_q.osc   <= osc_set   | (flags_q.osc   & ~osc_clr);
            flags_q.batt  <= batt_set  | (flags_q.batt  & ~batt_clr);
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       tick,
    input  logic [7:0] now_mon,
    input  logic [7:0] now_day,
    input  logic [7:0] now_hour,
    input  logic [7:0] now_min,
    input  logic [7:0] now_sec,
    input  logic       osc_fail_set,
    input  logic       batt_low_set,
    output logic       irq_n,
    output logic       sqw_en
);

    reg_t [NUM_FIELDS-1:0] alm_q;
    reg_t [NUM_FIELDS-1:0] now_vec;
    logic                  hit;
    logic                  flag_wr;
    logic                  alarm_en;
    flags_t                flags_q;

    assign now_vec[0] = now_mon;
    assign now_vec[1] = now_day;
    assign now_vec[2] = now_hour;
    assign now_vec[3] = now_min;
    assign now_vec[4] = now_sec;

    rtc_alarm_regs #(
        .NF   (NUM_FIELDS),
        .BASE (ALM_BASE)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .alm_q   (alm_q)
    );

    rtc_alarm_cmp #(
        .NF (NUM_FIELDS)
    ) u_cmp (
        .alm (alm_q),
        .now (now_vec),
        .hit (hit)
    );

    assign flag_wr = wr_en && (addr == FLAG_ADDR);

    rtc_alarm_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .alarm_set (tick & hit),
        .osc_set   (osc_fail_set),
        .batt_set  (batt_low_set),
        .alarm_clr (flag_wr & ~wr_data[AF_BIT]),
        .osc_clr   (flag_wr & ~wr_data[OF_BIT]),
        .batt_clr  (flag_wr & ~wr_data[BL_BIT]),
        .flags_q   (flags_q)
    );

    assign alarm_en = alm_q[FLD_MON][EN_BIT];
    assign sqw_en   = alm_q[FLD_MON][SQW_BIT];
    assign irq_n    = ~(flags_q.alarm & alarm_en);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ALM_BASE + ADDR_W'(i)) begin
                rd_data = alm_q[i];
            end
        end
        if (addr == FLAG_ADDR) begin
            rd_data = flags_to_byte(flags_q);
        end
    end

endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
    import rtc_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              wr_af_bit,
    input logic              wr_of_bit,
    input logic [7:0]        rd_data,
    input logic              tick,
    input logic              hit,
    input logic              af,
    input logic              osc,
    input logic              sqw_en,
    input logic              irq_n
);

    // R2: square-wave enable moves only on a month-register write
    p_sqw_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == ALM_BASE) |=> $stable(sqw_en));

    // R3: alarm flag holds unless a clearing write arrives
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (af && !(wr_en && addr == FLAG_ADDR && !wr_af_bit)) |=> af);

    // R4: interrupt falls only after a matching tick or a month write
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> (($past(tick) && $past(hit)) ||
                          ($past(wr_en) && $past(addr) == ALM_BASE)));

    // R6: flag rises only on a tick with a full match
    p_flag_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(af) |-> ($past(tick) && $past(hit)));

    // R7: oscillator-fail flag is sticky against non-clearing writes
    p_osc_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (osc && !(wr_en && addr == FLAG_ADDR && !wr_of_bit)) |=> osc);

    // R8: unused addresses read back zero
    p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (addr < ALM_BASE || addr > FLAG_ADDR) |-> rd_data == 8'h00);

    // R10: a matching tick always leaves the flag set
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && hit) |=> af);

endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_af_bit (wr_data[rtc_alarm_pkg::AF_BIT]),
    .wr_of_bit (wr_data[rtc_alarm_pkg::OF_BIT]),
    .rd_data   (rd_data),
    .tick      (tick),
    .hit       (hit),
    .af        (flags_q.alarm),
    .osc       (flags_q.osc),
    .sqw_en    (sqw_en),
    .irq_n     (irq_n)
);

// File: tb/rtc_alarm_match_test.sv
module rtc_alarm_match_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] addr;
    logic       wr_en;
    logic [7:0] wr_data;
    wire  [7:0] rd_data;
    logic       tick;
    logic [7:0] now_t [5];
    logic       osc_set;
    logic       bat_set;
    wire        irq_n;
    wire        sqw_en;

    always #4 clk = ~clk;  // 125 MHz

    rtc_alarm_match uut (
        .clk          (clk),
        .rst          (rst),
        .addr         (addr),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .tick         (tick),
        .now_mon      (now_t[0]),
        .now_day      (now_t[1]),
        .now_hour     (now_t[2]),
        .now_min      (now_t[3]),
        .now_sec      (now_t[4]),
        .osc_fail_set (osc_set),
        .batt_low_set (bat_set),
        .irq_n        (irq_n),
        .sqw_en       (sqw_en)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_alm [5];
    bit m_af, m_osc, m_bat;

    function automatic logic [7:0] mask_of(int i);
        return (i < 3) ? 8'h3F : 8'h7F;
    endfunction

    function automatic bit exp_hit();
        for (int i = 0; i < 5; i++) begin
            if ((m_alm[i] & mask_of(i)) != (now_t[i] & mask_of(i))) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [7:0] exp_flags();
        return {1'b0, m_af, 1'b0, m_bat, 1'b0, m_osc, 2'b00};
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a >= 5'h0A && a <= 5'h0E) m_alm[a - 5'h0A] = d;
        if (a == 5'h0F) begin
            m_af  = m_af  & d[6];
            m_bat = m_bat & d[4];
            m_osc = m_osc & d[2];
        end
    endtask

    task automatic rd_chk(logic [4:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        addr = a;
        #1;
        check8(tag, rd_data, exp);
    endtask

    task automatic tick_once(bit t);
        @(negedge clk);
        tick = t;
        if (t && exp_hit()) m_af = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic chk_pins(string tag);
        #1;
        check8({tag, " irq_n"}, {7'b0, irq_n}, {7'b0, !(m_af && m_alm[0][7])});
        check8({tag, " sqw_en"}, {7'b0, sqw_en}, {7'b0, m_alm[0][6]});
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; tick = 1'b0;
        osc_set = 1'b0; bat_set = 1'b0;
        for (int i = 0; i < 5; i++) begin now_t[i] = 8'h00; m_alm[i] = 8'h00; end
        m_af = 0; m_osc = 0; m_bat = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        for (int a = 10; a <= 15; a++) rd_chk(5'(a), 8'h00, "R9 reset readback");
        chk_pins("R9 reset");

        // R1: alarm bytes read back
        wr(5'h0A, 8'h12); wr(5'h0B, 8'h31); wr(5'h0C, 8'h23);
        wr(5'h0D, 8'h59); wr(5'h0E, 8'h45);
        for (int i = 0; i < 5; i++) rd_chk(5'(10 + i), m_alm[i], "R1 alarm readback");

        // R8: unused addresses
        @(negedge clk); addr = 5'h05; wr_data = 8'hA5; wr_en = 1'b1;
        @(negedge clk); addr = 5'h10; wr_data = 8'h5A;
        @(negedge clk); addr = 5'h1F; wr_data = 8'hFF;
        @(negedge clk); wr_en = 1'b0;
        rd_chk(5'h05, 8'h00, "R8 unused 0x05");
        rd_chk(5'h10, 8'h00, "R8 unused 0x10");
        rd_chk(5'h1F, 8'h00, "R8 unused 0x1F");
        for (int i = 0; i < 5; i++) rd_chk(5'(10 + i), m_alm[i], "R8 alarms untouched");
        rd_chk(5'h0F, 8'h00, "R8 flags untouched");

        // R2: square-wave bit separate from enable
        wr(5'h0A, 8'h52); chk_pins("R2 sqw set");
        wr(5'h0F, 8'h00); chk_pins("R2 sqw after flags write");
        wr(5'h0A, 8'h92); chk_pins("R2 enable without sqw");

        // R6 / R5: match with only unmasked upper bits differing
        now_t[0] = 8'hD2; now_t[1] = 8'hF1; now_t[2] = 8'hE3;
        now_t[3] = 8'hD9; now_t[4] = 8'hC5;
        tick_once(1'b0);
        rd_chk(5'h0F, exp_flags(), "R6 no tick no flag");
        tick_once(1'b1);
        rd_chk(5'h0F, exp_flags(), "R5 upper bits ignored, R6 flag set");
        check8("R5 flag expected", {1'b0, m_af, 6'b0}, 8'h40);
        chk_pins("R4 irq asserted");

        // R3: sticky against writing 1, cleared by 0
        wr(5'h0F, 8'h40);
        rd_chk(5'h0F, 8'h40, "R3 write one keeps flag");
        wr(5'h0F, 8'hBF);
        rd_chk(5'h0F, 8'h00, "R3 write zero clears flag");
        chk_pins("R4 irq released");

        // R5: mismatch inside the compared bits
        now_t[4] = 8'h44;
        tick_once(1'b1);
        rd_chk(5'h0F, 8'h00, "R5 second bit0 differs");
        now_t[4] = 8'h05;
        tick_once(1'b1);
        rd_chk(5'h0F, 8'h00, "R5 second bit6 differs");
        now_t[4] = 8'hC5; now_t[2] = 8'h03;
        tick_once(1'b1);
        rd_chk(5'h0F, 8'h00, "R5 hour bit5 differs");
        now_t[2] = 8'hE3;

        // R4: level follows enable while flag set
        tick_once(1'b1);
        wr(5'h0A, 8'h12); chk_pins("R4 flag set, enable off");
        wr(5'h0A, 8'h92); chk_pins("R4 flag set, enable on");
        wr(5'h0F, 8'h00);

        // R7: oscillator and battery flags
        @(negedge clk); osc_set = 1'b1;
        @(negedge clk); osc_set = 1'b0; bat_set = 1'b1;
        @(negedge clk); bat_set = 1'b0;
        m_osc = 1; m_bat = 1;
        rd_chk(5'h0F, 8'h14, "R7 both flags set");
        wr(5'h0F, 8'hFB);
        rd_chk(5'h0F, 8'h10, "R7 clear osc only");
        wr(5'h0F, 8'hEF);
        rd_chk(5'h0F, 8'h00, "R7 clear battery");

        // R10: matching tick together with a clearing write
        @(negedge clk);
        tick = 1'b1; addr = 5'h0F; wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        m_af = 1;
        rd_chk(5'h0F, 8'h40, "R10 set wins over clear");
        chk_pins("R10 irq");

        // random mix, R1 R3 R4 R5 R6
        for (int it = 0; it < 150; it++) begin
            bit want_hit;
            bit do_tick;
            for (int f = 0; f < 5; f++) wr(5'(10 + f), 8'($urandom));
            wr(5'h0F, 8'h00);
            want_hit = $urandom_range(0, 1) == 1;
            do_tick  = $urandom_range(0, 3) != 0;
            for (int f = 0; f < 5; f++) begin
                logic [7:0] r;
                r = 8'($urandom);
                now_t[f] = want_hit ? ((m_alm[f] & mask_of(f)) | (r & ~mask_of(f))) : r;
            end
            tick_once(do_tick);
            rd_chk(5'h0F, exp_flags(), "R6 random flags");
            chk_pins("R4 random pins");
            rd_chk(5'h0E, m_alm[4], "R1 random readback");
        end

        summary();
        $finish;
    end

endmodule